// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Controller

This block keeps the replacement state for a single set of a set-associative cache as a binary tree of direction bits, one bit per internal node, for a power-of-two number of ways. A combinational output always names the way the tree currently points at as the eviction candidate. The candidate is found by walking from the root towards a leaf. A bit of 1 steers the walk into the left subtree and a bit of 0 steers it into the right subtree.

The surrounding cache drives one access port: a strobe, a way index and an invalidate flag. On the clock edge where the strobe is high, every node on the path from the root to that way is rewritten. A hit makes the nodes point away from the way, so it becomes most recent. An invalidate makes them point toward it, so it becomes the next victim. Nodes whose subtrees do not contain the way keep their values. The node bits are stored in in-order position: bit n is the node that separates ways 0..n from ways n+1 and up. The root therefore sits in the middle of the vector.

Top module: `plru_tree_ctrl`

## Requirements
- R1: A synchronous reset with `rst` high clears every node bit to 0, so the victim output then reads WAYS-1.
- R2: The victim is found by starting at the root and following each node's bit: 1 selects the left half of that node's ways, and 0 selects the right half. At the lowest node, which covers ways b and b+1, the victim is b when the bit is 1 and b+1 when the bit is 0.
- R3: Node bit n, counted from vector index 0, sits in in-order position and splits ways 0..n from ways n+1 and up. With 8 ways, the vector bits 0..6 equal to 1,0,1,0,0,1,0 select way 5.
- R4: After a hit (`acc_valid`=1, `acc_inval`=0), each node on the path to the accessed way holds 1 if the way lies in its right subtree and 0 if the way lies in its left subtree. The accessed way is therefore not the victim in the next cycle.
- R5: After an invalidate (`acc_valid`=1, `acc_inval`=1), each node on the path holds the inverse of the hit value. The accessed way is the victim in the next cycle.
- R6: A node whose subtree does not contain the accessed way keeps its value across the access.
- R7: While `acc_valid` is 0, the tree state is unchanged whatever `acc_way` and `acc_inval` carry.
- R8: The victim depends only on the registered state. A change on the access port shows on `victim` after the next rising edge, never in the same cycle.
- R9: A hit and an invalidate cannot be requested together. When `acc_inval` is 1 the access is treated as an invalidate, so invalidation always takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access strobe; the state updates only when this is high |
| acc_way | input | $clog2(WAYS) | Way index of the access |
| acc_inval | input | 1 | 1 selects invalidate, 0 selects hit |
| victim | output | $clog2(WAYS) | Current eviction candidate |

## Verification
On every cycle the assertions check four properties: an invalidated way becomes the victim in the next cycle, a hit way never does, the victim holds steady while no access is strobed, and the victim reads the highest way as soon as reset is released. Other behaviours can only be shown through the bench's scenarios. These are the in-order layout, tested by building the seven-bit example state through a chosen access sequence, and the preservation of nodes off the access path. The bench checks both by comparing the victim after every random access with a recursive tree model. It also confirms that toggling the access inputs has no effect on the victim within the same cycle.

// File: rtl/plru_tree_ctrl.sv
module plru_tree_ctrl #(
  parameter int WAYS = 8,
  localparam int WAYW = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_valid,
  input  logic [WAYW-1:0] acc_way,
  input  logic            acc_inval,
  output logic [WAYW-1:0] victim
);

  function automatic int low_one(input int v);
    for (int i = 0; i < 31; i++)
      if (v[i]) return i;
    return 0;
  endfunction

  logic [NODES-1:0] tree, tree_nxt;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int P  = n + 1;
    localparam int H  = low_one(P);
    localparam int LO = P - (1 << H);
    localparam int HI = P + (1 << H) - 1;
    logic on_path, go_left;
    assign on_path = (int'(acc_way) >= LO) && (int'(acc_way) <= HI);
    assign go_left = int'(acc_way) <= n;
    assign tree_nxt[n] = on_path ? ~(go_left ^ acc_inval) : tree[n];
  end

  always_ff @(posedge clk) begin
    if (rst) tree <= '0;
    else if (acc_valid) tree <= tree_nxt;
  end

  always_comb begin
    int lo;
    lo = 0;
    for (int l = WAYW - 1; l >= 0; l--) begin
      if (!tree[lo + (1 << l) - 1]) lo = lo + (1 << l);
    end
    victim = WAYW'(lo);
  end

  // R5
  inval_becomes_victim_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_inval |=> victim == $past(acc_way));

  // R4
  hit_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_inval |=> victim != $past(acc_way));

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(victim));

  // R1
  reset_victim_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> victim == WAYW'(WAYS - 1));

endmodule

// File: tb/plru_tree_ctrl_test.sv
module plru_tree_ctrl_test;
  localparam int WAYS = 8;
  localparam int WAYW = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  logic clk = 0, rst = 1, acc_valid = 0, acc_inval = 0;
  logic [WAYW-1:0] acc_way = '0;
  logic [WAYW-1:0] victim;
  logic [NODES-1:0] model;
  int checks = 0, errors = 0;
  bit done = 0;

  plru_tree_ctrl #(.WAYS(WAYS)) uut (.clk(clk), .rst(rst), .acc_valid(acc_valid),
    .acc_way(acc_way), .acc_inval(acc_inval), .victim(victim));

  always #10 clk = ~clk;

  function automatic int pick(input logic [NODES-1:0] s, input int lo, input int hi, input int base);
    int mid;
    mid = (lo + hi) / 2;
    if (lo == hi) return s[lo] ? base : base + 1;
    if (s[mid]) return pick(s, lo, mid - 1, base);
    return pick(s, mid + 1, hi, base + mid - lo + 1);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] s, input int lo, input int hi,
                                             input int base, input int way, input bit inv);
    int mid, split;
    logic [NODES-1:0] r;
    r = s;
    mid = (lo + hi) / 2;
    split = base + mid - lo;
    if (way < base || way > base + hi - lo + 1) return r;
    r[mid] = (way <= split) ? inv : !inv;
    if (lo != hi) begin
      r = touch(r, lo, mid - 1, base, way, inv);
      r = touch(r, mid + 1, hi, split + 1, way, inv);
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: victim=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input bit v, input int w, input bit inv, input string req);
    @(negedge clk);
    acc_valid = v; acc_way = WAYW'(w); acc_inval = inv;
    #2;
    // R8: no same-cycle effect
    check("R8", int'(victim), pick(model, 0, NODES - 1, 0));
    @(posedge clk); #1;
    if (v) model = touch(model, 0, NODES - 1, 0, w, inv);
    check(req, int'(victim), pick(model, 0, NODES - 1, 0));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 check("R1", int'(victim), WAYS - 1);

    // R3: build state 1,0,1,0,0,1,0 -> way 5
    access(1, 0, 1, "R5");
    check("R5", int'(victim), 0);
    access(1, 2, 1, "R5");
    access(1, 6, 0, "R4");
    access(1, 5, 1, "R3");
    check("R3", int'(victim), 5);

    // R7: idle cycles with noisy inputs
    for (int k = 0; k < 20; k++) access(0, $urandom % WAYS, $urandom % 2, "R7");
    check("R7", int'(victim), 5);

    // R4 corner: hit every way in order; last hit way 7 -> victim from left
    for (int w = 0; w < WAYS; w++) begin
      access(1, w, 0, "R4");
      if (int'(victim) == w) check("R4", int'(victim), -1);
    end
    check("R2", int'(victim), 0);

    // R9: invalidate selected by flag at corner ways
    access(1, WAYS - 1, 1, "R9");
    check("R9", int'(victim), WAYS - 1);
    access(1, 0, 1, "R9");
    check("R9", int'(victim), 0);

    // R6 / R2: random mix checked against model
    for (int k = 0; k < 400; k++)
      access(($urandom % 4) != 0, $urandom % WAYS, ($urandom % 3) == 0, "R6");

    // R1 again: reset mid-run
    @(negedge clk); rst = 1; acc_valid = 0;
    @(negedge clk); rst = 0; model = '0;
    #1 check("R1", int'(victim), WAYS - 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule